// File: doc/BRIEF.md
# I/Q Serial Receive Data Transmitter

This block takes one filtered in-phase/quadrature sample pair per sample period, presented in parallel with a valid strobe, and ships it to a signal processor over three wires: a continuously running serial clock, a one-bit frame sync and a serial data line. Each pair leaves as a 32-bit frame made of two 16-bit words, the in-phase word first. Each word holds `SAMPLE_W` data bits sent most significant bit first, followed by a channel flag bit so that the receiver can tell the two words apart without counting frames.

The serial clock is the system clock divided by `CLK_DIV`. Data and frame sync change only on its rising edge, so a receiver samples them on the falling edge. Incoming pairs pass through a single holding register. A pair that arrives while a frame is being sent waits there and goes out directly after it. If yet another pair arrives first, it replaces the waiting one.

Top module: `iq_ser_tx`

## Requirements
- R1: A pair is sent as one frame of 2*(SAMPLE_W+1) bits. The I word comes first and then the Q word, and each word carries its SAMPLE_W data bits MSB first.
- R2: The last bit of each word is the channel flag: 0 ends the I word and 1 ends the Q word. Bit positions in the frame, first to last, are I data, 0, Q data, 1.
- R3: `rxc_o` runs at the clk rate divided by CLK_DIV whether frames are being sent or not. `rxd_o` and `rxfs_o` change only in the clock cycle in which `rxc_o` rises.
- R4: `rxfs_o` is high for exactly one `rxc_o` period, the one that carries the first bit of the I word, and is low for the other bits of the frame.
- R5: A pair captured while a frame is in progress starts its frame at the first `rxc_o` rise after the last bit of the current frame. Consecutive frame syncs are then exactly 2*(SAMPLE_W+1) `rxc_o` rises apart.
- R6: When a second pair is captured while a first one is still waiting, the second replaces the first. The replaced pair is never sent.
- R7: With no pair waiting and no frame in progress, `rxd_o` and `rxfs_o` stay low.
- R8: While `rst_n` is low, `rxc_o`, `rxd_o` and `rxfs_o` are low.
- R9: A pair captured while the block is idle has its frame sync appear within CLK_DIV clk cycles after the capturing edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Strobe: smp_i and smp_q hold a new pair this cycle |
| smp_i | input | SAMPLE_W | In-phase sample |
| smp_q | input | SAMPLE_W | Quadrature sample |
| rxc_o | output | 1 | Serial clock, clk divided by CLK_DIV |
| rxfs_o | output | 1 | Frame sync, high during the first bit of the I word |
| rxd_o | output | 1 | Serial data, updated on rxc_o rise |

## Verification
A bit counter that slips shows up within one frame. The flag bits land in the wrong positions, and the next frame sync arrives early or late relative to the 32-rise spacing. A wrong holding-register state shows up as a frame that is dropped, repeated or out of date. The bench catches it on the next frame, because it matches every received frame against an ordered list of the pairs that should be sent. A divider fault shows up within one serial clock period as a wrong rise count or as data moving off the rising edge.

// File: rtl/iq_ser_pkg.sv
package iq_ser_pkg;
   // channel flag carried in the last bit of each word
   typedef enum logic {
      CH_I = 1'b0,
      CH_Q = 1'b1
   } iq_chan_e;
endpackage

// File: rtl/iq_rxclk_gen.sv
module iq_rxclk_gen #(
   parameter int CLK_DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   output logic bit_tick,
   output logic rxc
);
   generate
      if (CLK_DIV == 2) begin : g_toggle
         // divide by two: a single toggle flop
         always_ff @(posedge clk) begin
            if (!rst_n) rxc <= 1'b0;
            else        rxc <= ~rxc;
         end
         assign bit_tick = ~rxc;
      end else begin : g_count
         localparam int CW   = $clog2(CLK_DIV);
         localparam int HALF = CLK_DIV / 2;
         logic [CW-1:0] cnt;
         assign bit_tick = (cnt == CW'(CLK_DIV - 1));
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               cnt <= '0;
               rxc <= 1'b0;
            end else if (bit_tick) begin
               cnt <= '0;
               rxc <= 1'b1;
            end else begin
               cnt <= cnt + 1'b1;
               if (cnt == CW'(HALF - 1)) rxc <= 1'b0;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/iq_pair_hold.sv
module iq_pair_hold #(
   parameter int SAMPLE_W = 15
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   input  logic [SAMPLE_W-1:0] in_i,
   input  logic [SAMPLE_W-1:0] in_q,
   input  logic                take,
   output logic                pend,
   output logic [SAMPLE_W-1:0] hold_i,
   output logic [SAMPLE_W-1:0] hold_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend   <= 1'b0;
         hold_i <= '0;
         hold_q <= '0;
      end else begin
         if (in_valid) begin
            // newest pair always wins the single slot
            hold_i <= in_i;
            hold_q <= in_q;
            pend   <= 1'b1;
         end else if (take) begin
            pend <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/iq_frame_shifter.sv
module iq_frame_shifter
   import iq_ser_pkg::*;
#(
   parameter int SAMPLE_W = 15,
   localparam int FR      = 2 * (SAMPLE_W + 1),
   localparam int BCW     = $clog2(FR)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bit_tick,
   input  logic                pend,
   input  logic [SAMPLE_W-1:0] hold_i,
   input  logic [SAMPLE_W-1:0] hold_q,
   output logic                take,
   output logic                busy,
   output logic [BCW-1:0]      bit_cnt,
   output logic                sdata,
   output logic                fsync
);
   logic [FR-1:0] frame_w;
   logic [FR-1:0] sreg;
   logic          at_end;

   assign frame_w = {hold_i, logic'(CH_I), hold_q, logic'(CH_Q)};
   assign at_end  = !busy || (bit_cnt == BCW'(FR - 1));
   assign take    = bit_tick && at_end && pend;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         bit_cnt <= '0;
         sreg    <= '0;
         sdata   <= 1'b0;
         fsync   <= 1'b0;
      end else if (bit_tick) begin
         if (at_end) begin
            bit_cnt <= '0;
            if (pend) begin
               busy  <= 1'b1;
               sdata <= frame_w[FR-1];
               sreg  <= {frame_w[FR-2:0], 1'b0};
               fsync <= 1'b1;
            end else begin
               busy  <= 1'b0;
               sdata <= 1'b0;
               sreg  <= '0;
               fsync <= 1'b0;
            end
         end else begin
            bit_cnt <= bit_cnt + 1'b1;
            sdata   <= sreg[FR-1];
            sreg    <= {sreg[FR-2:0], 1'b0};
            fsync   <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/iq_ser_tx.sv
module iq_ser_tx #(
   parameter int SAMPLE_W = 15,
   parameter int CLK_DIV  = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                smp_valid,
   input  logic [SAMPLE_W-1:0] smp_i,
   input  logic [SAMPLE_W-1:0] smp_q,
   output logic                rxc_o,
   output logic                rxfs_o,
   output logic                rxd_o
);
   localparam int FR  = 2 * (SAMPLE_W + 1);
   localparam int BCW = $clog2(FR);

   generate
      if (SAMPLE_W < 1) begin : g_bad_width
         $error("SAMPLE_W must be at least 1");
      end
      if (CLK_DIV < 2 || (CLK_DIV % 2) != 0) begin : g_bad_div
         $error("CLK_DIV must be even and at least 2");
      end
   endgenerate

   logic                bit_tick;
   logic                pend;
   logic                frm_take;
   logic                busy;
   logic [BCW-1:0]      bit_cnt;
   logic [SAMPLE_W-1:0] hold_i;
   logic [SAMPLE_W-1:0] hold_q;

   iq_rxclk_gen #(.CLK_DIV(CLK_DIV)) u_clk (
      .clk      (clk),
      .rst_n    (rst_n),
      .bit_tick (bit_tick),
      .rxc      (rxc_o)
   );

   iq_pair_hold #(.SAMPLE_W(SAMPLE_W)) u_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (smp_valid),
      .in_i     (smp_i),
      .in_q     (smp_q),
      .take     (frm_take),
      .pend     (pend),
      .hold_i   (hold_i),
      .hold_q   (hold_q)
   );

   iq_frame_shifter #(.SAMPLE_W(SAMPLE_W)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .bit_tick (bit_tick),
      .pend     (pend),
      .hold_i   (hold_i),
      .hold_q   (hold_q),
      .take     (frm_take),
      .busy     (busy),
      .bit_cnt  (bit_cnt),
      .sdata    (rxd_o),
      .fsync    (rxfs_o)
   );
endmodule

// File: rtl/iq_ser_tx_chk.sv
module iq_ser_tx_chk #(
   parameter int SAMPLE_W = 15,
   parameter int CLK_DIV  = 2,
   localparam int FR      = 2 * (SAMPLE_W + 1),
   localparam int BCW     = $clog2(FR)
) (
   input logic           clk,
   input logic           rst_n,
   input logic           rxc_o,
   input logic           rxd_o,
   input logic           rxfs_o,
   input logic           pend,
   input logic           busy,
   input logic           frm_take,
   input logic           smp_valid,
   input logic [BCW-1:0] bit_cnt
);
   assert_edge_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !$rose(rxc_o) |-> ($stable(rxd_o) && $stable(rxfs_o)));

   assert_rxc_min_period_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rxc_o) |=> !$rose(rxc_o));

   assert_fs_first_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rxfs_o |-> (busy && bit_cnt == '0));

   assert_flag_i_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && bit_cnt == BCW'(SAMPLE_W)) |-> !rxd_o);

   assert_flag_q_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && bit_cnt == BCW'(FR - 1)) |-> rxd_o);

   assert_pair_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && !frm_take) |=> pend);

   assert_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
      smp_valid |=> pend);

   assert_idle_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!rxd_o && !rxfs_o));
endmodule

bind iq_ser_tx iq_ser_tx_chk #(.SAMPLE_W(SAMPLE_W), .CLK_DIV(CLK_DIV)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rxc_o     (rxc_o),
   .rxd_o     (rxd_o),
   .rxfs_o    (rxfs_o),
   .pend      (pend),
   .busy      (busy),
   .frm_take  (frm_take),
   .smp_valid (smp_valid),
   .bit_cnt   (bit_cnt)
);

// File: tb/tb_iq_ser_tx.sv
module tb_iq_ser_tx;
   localparam int SW  = 15;
   localparam int DIV = 2;
   localparam int FR  = 2 * (SW + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          smp_valid = 1'b0;
   logic [SW-1:0] smp_i = '0;
   logic [SW-1:0] smp_q = '0;
   logic          rxc_o, rxfs_o, rxd_o;

   always #2 clk = ~clk;

   iq_ser_tx #(.SAMPLE_W(SW), .CLK_DIV(DIV)) dut (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
      .smp_i(smp_i), .smp_q(smp_q),
      .rxc_o(rxc_o), .rxfs_o(rxfs_o), .rxd_o(rxd_o)
   );

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   // expected pairs, written by stimulus, read by monitor
   logic [SW-1:0] exp_i [0:127];
   logic [SW-1:0] exp_q [0:127];
   int wr_idx = 0;
   int rd_idx = 0;

   // monitor state
   int mchk = 0, mfail = 0;
   int rise_cnt = 0, nfs = 0, idle_viol = 0, nbits = 0;
   int fs_rise_log [0:127];
   int fs_cyc_log  [0:127];
   logic prev_rxc = 1'b0;
   logic collecting = 1'b0;
   logic [FR-1:0] cur = '0;

   function automatic logic [FR-1:0] frame_of(logic [SW-1:0] i, logic [SW-1:0] q);
      return {i, 1'b0, q, 1'b1};
   endfunction

   always @(negedge clk) begin
      if (rst_n && rxc_o && !prev_rxc) begin
         rise_cnt = rise_cnt + 1;
         if (rxfs_o) begin
            if (collecting) begin
               mchk = mchk + 1; mfail = mfail + 1;
               $display("FAIL R4: frame sync after %0d bits, expected %0d", nbits, FR);
            end
            collecting = 1'b1;
            nbits = 1;
            cur = {{(FR-1){1'b0}}, rxd_o};
            fs_rise_log[nfs] = rise_cnt;
            fs_cyc_log[nfs]  = cyc;
            nfs = nfs + 1;
         end else if (collecting) begin
            cur = {cur[FR-2:0], rxd_o};
            nbits = nbits + 1;
            if (nbits == FR) begin
               collecting = 1'b0;
               mchk = mchk + 1;
               if (rd_idx >= wr_idx) begin
                  mfail = mfail + 1;
                  $display("FAIL R6: unexpected frame %h, expected none", cur);
               end else begin
                  if (cur[0] !== 1'b1 || cur[SW+1] !== 1'b0) begin
                     mfail = mfail + 1;
                     $display("FAIL R2: flags I=%b Q=%b, expected I=0 Q=1", cur[SW+1], cur[0]);
                  end
                  if (cur !== frame_of(exp_i[rd_idx], exp_q[rd_idx])) begin
                     mfail = mfail + 1;
                     $display("FAIL R1: frame %h, expected %h", cur,
                              frame_of(exp_i[rd_idx], exp_q[rd_idx]));
                  end
                  rd_idx = rd_idx + 1;
               end
            end
         end else if (rxd_o) begin
            idle_viol = idle_viol + 1;
         end
      end
      prev_rxc = rxc_o;
   end

   int nchk = 0, nfail = 0;
   logic done = 1'b0;

   task automatic check(input string req, input int got, input int exp);
      nchk = nchk + 1;
      if (got != exp) begin
         nfail = nfail + 1;
         $display("FAIL %s: got %0d, expected %0d", req, got, exp);
      end
   endtask

   task automatic report(input int extra);
      $display("  [TB] %0d tests run, %0d failed", nchk + mchk + extra, nfail + mfail + extra);
      $finish;
   endtask

   task automatic push(input logic [SW-1:0] i, input logic [SW-1:0] q, input bit expect_out,
                       output int at_cyc);
      @(negedge clk);
      smp_valid = 1'b1; smp_i = i; smp_q = q;
      at_cyc = cyc;
      if (expect_out) begin
         exp_i[wr_idx] = i; exp_q[wr_idx] = q;
         wr_idx = wr_idx + 1;
      end
      @(negedge clk);
      smp_valid = 1'b0;
   endtask

   task automatic wait_drain();
      while (rd_idx != wr_idx || collecting) @(negedge clk);
   endtask

   initial begin
      int pc, n0, r0, v0, nb;
      void'($urandom(32'd2024));
      repeat (5) @(negedge clk);
      // R8: outputs low during reset
      check("R8 rxc", int'(rxc_o), 0);
      check("R8 rxd", int'(rxd_o), 0);
      check("R8 rxfs", int'(rxfs_o), 0);
      rst_n = 1'b1;
      repeat (7) @(negedge clk);

      // R9 + R1 corner: all-ones I, all-zeros Q, from idle
      push('1, '0, 1'b1, pc);
      while (nfs < 1) @(negedge clk);
      nb = fs_cyc_log[0] - pc;
      check("R9 latency in range", int'(nb >= 2 && nb <= DIV + 1), 1);
      wait_drain();

      // R5: pair arriving mid-frame goes out right after
      push(15'h2AAA, 15'h5555, 1'b1, pc);
      while (nfs < 2) @(negedge clk);
      repeat (10) @(negedge clk);
      push(15'h0001, 15'h4000, 1'b1, pc);
      wait_drain();
      check("R5 frame spacing", fs_rise_log[2] - fs_rise_log[1], FR);

      // R6: replaced pair is never sent
      n0 = nfs;
      push(15'h1234, 15'h0F0F, 1'b1, pc);
      while (nfs == n0) @(negedge clk);
      repeat (5) @(negedge clk);
      push(15'h7777, 15'h7777, 1'b0, pc);
      push(15'h0BCD, 15'h3210, 1'b1, pc);
      wait_drain();
      repeat (3 * FR * DIV) @(negedge clk);
      check("R6 frames sent", nfs, wr_idx);

      // R7 / R3: idle window
      r0 = rise_cnt; v0 = idle_viol;
      repeat (200) @(negedge clk);
      check("R3 rxc rises in idle", rise_cnt - r0, 200 / DIV);
      check("R7 idle data low", idle_viol - v0, 0);
      check("R7 idle sync low", int'(rxfs_o), 0);

      // random pairs, spaced so that each one is sent
      for (int k = 0; k < 40; k++) begin
         push(SW'($urandom), SW'($urandom), 1'b1, pc);
         repeat ($urandom_range(140, 70)) @(negedge clk);
      end
      wait_drain();
      repeat (2 * FR * DIV) @(negedge clk);
      check("R1 all pairs sent", rd_idx, wr_idx);
      check("R4 one sync per frame", nfs, wr_idx);
      check("R7 no data outside frames", idle_viol, 0);
      done = 1'b1;
      report(0);
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         $display("FAIL watchdog: run did not complete, got timeout, expected finish");
         report(1);
      end
   end
endmodule